// File: doc/BRIEF.md
# Multi-Function Capture Compare Timer

This block is a general-purpose timer for a peripheral subsystem. A 7-bit prescaler divides the system clock into a count tick, and each tick advances one 16-bit free-running counter. Two channels share that counter, and each channel is set on its own to capture or to compare. A capture channel latches the counter when its input pin shows the chosen edge. A compare channel changes its output pin when the counter reaches a stored value.

An external pulse counter and a PWM generator sit beside the channels. The PWM generator uses the same tick, so its frequency comes from the prescaler and the period register. New period and duty values wait in shadow registers until the current period ends. Every event sets a sticky flag that is cleared by writing a one to it. The enabled flags are ORed onto a single interrupt line.

Software drives the block through a plain register write port and a combinational read port. The map is as follows: 0 holds control (prescale in bits 6:0, run in bit 7) and 1 holds the counter. 2 and 3 are channel 0 config and value, and 4 and 5 are channel 1 config and value. 6 is the pulse count, 7 the PWM period, 8 the PWM duty, 9 the flags and 10 the interrupt enables. The counter, the pulse count and the channel value registers can all be loaded by a write.

Top module: `cc_timer`

## Requirements
- R1: While run is 1, the counter advances by one on every (PSC+1)-th clock, with the prescale phase restarting at each control write. While run is 0, the counter holds its value.
- R2: A write to the counter address loads the counter. A tick at 0xFFFF wraps it to 0 and sets flag bit 0.
- R3: A channel in capture mode (config bit 0 = 0) latches the counter into its value register on the edge chosen by config bit 1 (0 rising, 1 falling). The capture lands on the third clock after the pin changes. It also sets the channel's event flag (bit 1 for channel 0, bit 2 for channel 1). The opposite edge has no effect.
- R4: A capture that occurs while the channel's event flag is still set also sets its overrun flag (bit 3 for channel 0, bit 4 for channel 1).
- R5: A channel in compare mode (config bit 0 = 1) acts on the tick that moves the counter onto its value register. It sets the channel's event flag and applies the action in config bits 3:2 to its output pin: 0 none, 1 set, 2 clear, 3 toggle.
- R6: Each rising edge on the pulse input advances a 16-bit pulse count that wraps from 0xFFFF to 0. A write to the pulse address loads the count.
- R7: The PWM period is PER+1 ticks, and the output is high while the period phase is below DUTY.
- R8: Written period and duty values take effect only at the start of the next PWM period.
- R9: Flags stay set until a one is written to their bit at the flag address. When a set and a clear meet in the same cycle, the set wins. The interrupt is high when any flag with its enable bit set is high.
- R10: After reset all registers read 0, and the interrupt, PWM and compare outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| cc_in | input | 2 | Capture input pins, one per channel |
| cc_out | output | 2 | Compare output pins, one per channel |
| pulse_in | input | 1 | External pulse input |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Combined interrupt |

## Verification
A prescale phase that slips shows up as a counter reading off by one tick after a timed run window. The count is read the cycle after run is cleared. A wrong edge select or a broken synchronizer depth changes the captured value or the event flag three clocks after the pin moves. A shadow register that loads too early changes the PWM level inside the period in which it was written, within one tick of the affected phase. A lost flag or a wrong interrupt mask is visible on irq in the cycle after the enable or flag write.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    pin_act_e act;       // bits 3:2
    logic     fall;      // bit 1: capture on falling edge
    logic     cmp_mode;  // bit 0: 1 compare, 0 capture
  } ch_cfg_t;
endpackage

// File: rtl/cct_timebase.sv
module cct_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick,
  output logic             wrap
);
  logic [PSC_W-1:0] phase;

  assign tick    = run && (phase == psc);
  assign cnt_nxt = cnt + CNT_W'(1);
  assign wrap    = tick && !load && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || !run || tick) begin
      phase <= '0;
    end else begin
      phase <= phase + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic hit
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign hit = fall_sel ? (!sh[STAGES-1] && sh[STAGES])
                        : (sh[STAGES-1] && !sh[STAGES]);
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] val_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             tick,
  input  logic             pin_in,
  output logic [CNT_W-1:0] val,
  output logic             pin_out,
  output logic             evt,
  output logic             cap_evt
);
  logic edge_hit;
  logic cmp_hit;

  cct_sync_edge #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pin_in),
    .fall_sel (cfg.fall),
    .hit      (edge_hit)
  );

  assign cap_evt = !cfg.cmp_mode && edge_hit;
  assign cmp_hit = cfg.cmp_mode && tick && (cnt_nxt == val);
  assign evt     = cap_evt || cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (cap_evt) begin
      val <= cnt;
    end else if (val_wr) begin
      val <= val_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out <= 1'b0;
    end else if (cmp_hit) begin
      case (cfg.act)
        ACT_SET: pin_out <= 1'b1;
        ACT_CLR: pin_out <= 1'b0;
        ACT_TGL: pin_out <= !pin_out;
        default: pin_out <= pin_out;
      endcase
    end
  end
endmodule

// File: rtl/cct_pwm.sv
module cct_pwm #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_sh,
  input  logic [CNT_W-1:0] duty_sh,
  output logic             pwm_out,
  output logic [CNT_W-1:0] duty_live
);
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] per_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      per_live  <= '0;
      duty_live <= '0;
    end else if (tick) begin
      if (phase >= per_live) begin
        phase     <= '0;
        per_live  <= per_sh;
        duty_live <= duty_sh;
      end else begin
        phase <= phase + CNT_W'(1);
      end
    end
  end

  assign pwm_out = (phase < duty_live);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 7,
  parameter int NCH   = 2,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [NCH-1:0]   cc_in,
  output logic [NCH-1:0]   cc_out,
  input  logic             pulse_in,
  output logic             pwm_out,
  output logic             irq
);
  localparam int A_CTRL  = 0;
  localparam int A_CNT   = 1;
  localparam int CH_BASE = 2;
  localparam int A_PULSE = CH_BASE + 2*NCH;
  localparam int A_PER   = A_PULSE + 1;
  localparam int A_DUTY  = A_PULSE + 2;
  localparam int A_FLAG  = A_PULSE + 3;
  localparam int A_IEN   = A_PULSE + 4;
  localparam int FW      = 1 + 2*NCH;

  logic             run_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] per_q, duty_q, pulse_cnt;
  logic [FW-1:0]    flags_q, ien_q, flag_set, flag_clr;
  ch_cfg_t          cfg_q [NCH];
  logic [CNT_W-1:0] ch_val [NCH];
  logic [NCH-1:0]   ch_evt, ch_cap;
  logic [CNT_W-1:0] cnt, cnt_nxt, duty_live;
  logic             tick, wrap, pulse_hit;
  logic             ctrl_wr, cnt_wr, pulse_wr;

  assign ctrl_wr  = wr_en && (wr_addr == AW'(A_CTRL));
  assign cnt_wr   = wr_en && (wr_addr == AW'(A_CNT));
  assign pulse_wr = wr_en && (wr_addr == AW'(A_PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      psc_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        psc_q <= wr_data[PSC_W-1:0];
        run_q <= wr_data[PSC_W];
      end
      if (wr_addr == AW'(A_PER))  per_q  <= wr_data;
      if (wr_addr == AW'(A_DUTY)) duty_q <= wr_data;
      if (wr_addr == AW'(A_IEN))  ien_q  <= wr_data[FW-1:0];
    end
  end

  cct_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .psc      (psc_q),
    .restart  (ctrl_wr),
    .load     (cnt_wr),
    .load_val (wr_data),
    .cnt      (cnt),
    .cnt_nxt  (cnt_nxt),
    .tick     (tick),
    .wrap     (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cfg_wr, val_wr;
    assign cfg_wr = wr_en && (wr_addr == AW'(CH_BASE + 2*i));
    assign val_wr = wr_en && (wr_addr == AW'(CH_BASE + 2*i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[i] <= '0;
      else if (cfg_wr) cfg_q[i] <= ch_cfg_t'(wr_data[$bits(ch_cfg_t)-1:0]);
    end

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg_q[i]),
      .val_wr    (val_wr),
      .val_wdata (wr_data),
      .cnt       (cnt),
      .cnt_nxt   (cnt_nxt),
      .tick      (tick),
      .pin_in    (cc_in[i]),
      .val       (ch_val[i]),
      .pin_out   (cc_out[i]),
      .evt       (ch_evt[i]),
      .cap_evt   (ch_cap[i])
    );
  end

  cct_sync_edge #(.STAGES(2)) u_pulse_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (pulse_in),
    .fall_sel (1'b0),
    .hit      (pulse_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_cnt <= '0;
    else if (pulse_wr)  pulse_cnt <= wr_data;
    else if (pulse_hit) pulse_cnt <= pulse_cnt + CNT_W'(1);
  end

  cct_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .per_sh    (per_q),
    .duty_sh   (duty_q),
    .pwm_out   (pwm_out),
    .duty_live (duty_live)
  );

  assign flag_set = {ch_cap & flags_q[NCH:1], ch_evt, wrap};
  assign flag_clr = (wr_en && (wr_addr == AW'(A_FLAG))) ? wr_data[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = |(flags_q & ien_q);

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTRL))  rd_data = CNT_W'({run_q, psc_q});
    if (rd_addr == AW'(A_CNT))   rd_data = cnt;
    if (rd_addr == AW'(A_PULSE)) rd_data = pulse_cnt;
    if (rd_addr == AW'(A_PER))   rd_data = per_q;
    if (rd_addr == AW'(A_DUTY))  rd_data = duty_q;
    if (rd_addr == AW'(A_FLAG))  rd_data = CNT_W'(flags_q);
    if (rd_addr == AW'(A_IEN))   rd_data = CNT_W'(ien_q);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(CH_BASE + 2*i))     rd_data = CNT_W'(cfg_q[i]);
      if (rd_addr == AW'(CH_BASE + 2*i + 1)) rd_data = ch_val[i];
    end
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             run,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [2*NCH:0]   flags,
  input logic [CNT_W-1:0] pulse_count,
  input logic             pwm_out,
  input logic [CNT_W-1:0] duty_live
);
  localparam int A_CNT   = 1;
  localparam int A_PULSE = 2 + 2*NCH;
  localparam int A_FLAG  = A_PULSE + 3;
  localparam int FW      = 1 + 2*NCH;

  logic          cnt_ld, pulse_ld;
  logic [FW-1:0] keep;

  assign cnt_ld   = wr_en && (wr_addr == AW'(A_CNT));
  assign pulse_ld = wr_en && (wr_addr == AW'(A_PULSE));
  assign keep     = flags & ~((wr_en && (wr_addr == AW'(A_FLAG))) ? wr_data[FW-1:0] : '0);

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R2
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_ld && cnt == {CNT_W{1'b1}}) |=> flags[0]);

  // R6
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_ld |=> (pulse_count == $past(pulse_count) ||
                   pulse_count == $past(pulse_count) + CNT_W'(1)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(keep)) == $past(keep)));

  // R7
  pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_live == '0) |-> !pwm_out);
endmodule

bind cc_timer cct_checker #(.CNT_W(CNT_W), .NCH(NCH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .run         (run_q),
  .tick        (tick),
  .cnt         (cnt),
  .flags       (flags_q),
  .pulse_count (pulse_cnt),
  .pwm_out     (pwm_out),
  .duty_live   (duty_live)
);

// File: tb/cc_timer_tb.sv
module cc_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  cc_in = '0;
  logic [1:0]  cc_out;
  logic        pulse_in = 1'b0;
  logic        pwm_out;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] r;

  localparam logic [3:0] A_CTRL = 4'd0, A_CNT = 4'd1, A_C0CFG = 4'd2, A_C0VAL = 4'd3,
                         A_C1CFG = 4'd4, A_C1VAL = 4'd5, A_PULSE = 4'd6, A_PER = 4'd7,
                         A_DUTY = 4'd8, A_FLAG = 4'd9, A_IEN = 4'd10;

  // {prescale, extra cycles M, expected count = (M+1)/(prescale+1)}
  localparam logic [38:0] VEC [5] = '{
    {7'd0,   16'd9,   16'd10},
    {7'd3,   16'd19,  16'd5},
    {7'd2,   16'd10,  16'd3},
    {7'd127, 16'd255, 16'd2},
    {7'd1,   16'd0,   16'd0}
  };

  cc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cc_in(cc_in), .cc_out(cc_out),
    .pulse_in(pulse_in), .pwm_out(pwm_out), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_once();
    pulse_in = 1'b1; wait_n(3);
    pulse_in = 1'b0; wait_n(3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int hi;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R10 reset state
    rd(A_CNT, r);  chk("R10 cnt", r, 16'h0);
    rd(A_FLAG, r); chk("R10 flags", r, 16'h0);
    rd(A_CTRL, r); chk("R10 ctrl", r, 16'h0);
    chk("R10 outputs", {13'd0, irq, pwm_out, cc_out[0]}, 16'h0);

    // R1 table of prescale runs
    for (int i = 0; i < 5; i++) begin
      logic [6:0]  p;
      logic [15:0] m, e;
      {p, m, e} = VEC[i];
      wait_n(1);
      wr(A_CNT, 16'h0);
      wr(A_CTRL, {8'd0, 1'b1, p});
      wait_n(int'(m));
      wr(A_CTRL, {8'd0, 1'b0, p});
      rd(A_CNT, r); chk("R1 prescaled count", r, e);
      wait_n(5);
      rd(A_CNT, r); chk("R1 hold while stopped", r, e);
    end

    // R2 wrap and flag; R9 irq masking and clear
    wr(A_CNT, 16'hFFFE);
    wr(A_CTRL, 16'h0080);
    wait_n(1);
    wr(A_CTRL, 16'h0000);
    rd(A_CNT, r);  chk("R2 wrapped count", r, 16'h0000);
    rd(A_FLAG, r); chk("R2 overflow flag", r, 16'h0001);
    chk("R9 irq masked", {15'd0, irq}, 16'h0);
    wr(A_IEN, 16'h0001);
    chk("R9 irq enabled", {15'd0, irq}, 16'h1);
    wr(A_FLAG, 16'h0001);
    rd(A_FLAG, r); chk("R9 flag cleared", r, 16'h0);
    chk("R9 irq dropped", {15'd0, irq}, 16'h0);

    // R3 capture rising on channel 0
    wr(A_CNT, 16'h1234);
    cc_in[0] = 1'b1; wait_n(4);
    rd(A_C0VAL, r); chk("R3 capture value", r, 16'h1234);
    rd(A_FLAG, r);  chk("R3 capture flag", r, 16'h0002);
    wr(A_CNT, 16'h2222);
    cc_in[0] = 1'b0; wait_n(4);
    rd(A_C0VAL, r); chk("R3 falling edge ignored", r, 16'h1234);
    // R4 second capture with flag still set
    cc_in[0] = 1'b1; wait_n(4);
    rd(A_C0VAL, r); chk("R4 recapture value", r, 16'h2222);
    rd(A_FLAG, r);  chk("R4 overrun flag", r, 16'h000A);
    wr(A_FLAG, 16'h001F);

    // R3 capture falling on channel 1
    wr(A_C1CFG, 16'h0002);
    cc_in[1] = 1'b1; wait_n(4);
    rd(A_FLAG, r);  chk("R3 rising ignored in falling mode", r, 16'h0000);
    cc_in[1] = 1'b0; wait_n(4);
    rd(A_C1VAL, r); chk("R3 falling capture value", r, 16'h2222);
    rd(A_FLAG, r);  chk("R3 ch1 flag, no overrun", r, 16'h0004);
    wr(A_FLAG, 16'h001F);

    // R5 compare toggle, clear, set
    wr(A_C0CFG, 16'h000D);
    wr(A_C0VAL, 16'h0100);
    wr(A_CNT, 16'h00FE);
    wr(A_CTRL, 16'h0080); wait_n(4); wr(A_CTRL, 16'h0000);
    chk("R5 toggle output", {15'd0, cc_out[0]}, 16'h1);
    rd(A_FLAG, r); chk("R5 compare flag", r, 16'h0002);
    wr(A_C0CFG, 16'h0009);
    wr(A_CNT, 16'h00FE);
    wr(A_CTRL, 16'h0080); wait_n(4); wr(A_CTRL, 16'h0000);
    chk("R5 clear output", {15'd0, cc_out[0]}, 16'h0);
    wr(A_FLAG, 16'h001F);
    wr(A_C1CFG, 16'h0005);
    wr(A_C1VAL, 16'h0000);
    wr(A_CNT, 16'hFFFE);
    wr(A_CTRL, 16'h0080); wait_n(1); wr(A_CTRL, 16'h0000);
    chk("R5 set output on wrap", {14'd0, cc_out}, 16'h2);
    rd(A_FLAG, r); chk("R5 ch1 and overflow flags", r, 16'h0005);
    wr(A_FLAG, 16'h001F);

    // R6 pulse counting and wrap
    wr(A_PULSE, 16'h0000);
    pulse_once(); pulse_once(); pulse_once();
    rd(A_PULSE, r); chk("R6 three pulses", r, 16'h0003);
    wr(A_PULSE, 16'hFFFF);
    pulse_once();
    rd(A_PULSE, r); chk("R6 pulse wrap", r, 16'h0000);

    // R7 duty ratio
    wr(A_PER, 16'd3);
    wr(A_DUTY, 16'd2);
    wr(A_CTRL, 16'h0080);
    wait_n(4);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk("R7 high cycles in 10 periods", 16'(hi), 16'd20);

    // R8 shadow takes effect at next period only
    wr(A_CTRL, 16'h0089);
    @(posedge pwm_out);
    @(negedge clk);
    wr(A_DUTY, 16'd4);
    wait_n(23);
    chk("R8 old duty in current period", {15'd0, pwm_out}, 16'h0);
    wait_n(40);
    chk("R8 new duty next period", {15'd0, pwm_out}, 16'h1);
    wr(A_CTRL, 16'h0000);

    summary();
  end
endmodule